// File: doc/BRIEF.md
# Trimmable Nanosecond Time Counter

This block keeps a free-running time count for precision time stamping. On every enabled clock it adds a programmable nanosecond step to the count, not a step of one. To trim the rate in parts per billion, a programmable correction interval can be set. Once per interval, one substitute step takes the place of the normal step, so the clock runs slightly fast or slightly slow against its reference.

In period-wrap mode the count rolls over at a programmable period. A typical period is 2^31, which gives a 31-bit time base. Outside that mode the count rolls over naturally at 2^32. Each rollover produces a one-cycle pulse that compare logic can use.

Software reaches the block through a simple register port: synchronous writes and a combinational read. Writing the capture bit of the control register copies the live count into a snapshot, which is read back at the time address. Writing the time address loads the count directly.

The block has two state machines:
- Trim sequencer, with states TRIM_OFF, TRIM_WAIT and TRIM_FIRE. Its transitions are:
  - A correction write of a nonzero value goes to TRIM_WAIT.
  - A correction write of zero goes to TRIM_OFF.
  - From TRIM_WAIT it goes to TRIM_FIRE when the remaining interval reaches one.
  - From TRIM_FIRE it goes back to TRIM_WAIT with the interval reloaded.
- Capture sequencer, with states CAP_IDLE, CAP_ARMED and CAP_HOLD. Its transitions are:
  - A capture request goes from CAP_IDLE to CAP_ARMED.
  - From CAP_ARMED it goes to CAP_HOLD, and the snapshot is taken on that edge.
  - From CAP_HOLD it goes back to CAP_IDLE.

Top module: `ns_time_counter`

## Requirements
- R1: After reset the count, the snapshot and all registers are zero, `wrap_pulse` is low, and every readable address returns zero.
- R2: When control bit 0 is 1, the count advances on each clock by the normal step, which is bits [6:0] of the increment register (address 4).
- R3: When control bit 0 is 0 and the time address is not written, the count holds. Both the count and the trim sequence are frozen.
- R4: A write of N≠0 to the correction register (address 3) restarts trimming. After the write, N enabled clocks use the normal step and the next enabled clock uses the substitute step, which is bits [14:8] of the increment register. This repeats every N+1 enabled clocks.
- R5: While the correction register holds 0, the substitute step is never used.
- R6: Period-wrap mode is active only when control bits [5:4] are both 1. In this mode, if the count plus the step reaches or exceeds the period register (address 2), the new count is (count + step − period). Otherwise the new count is count + step modulo 2^32.
- R7: `wrap_pulse` is high for exactly one cycle for each rollover, in the cycle where the wrapped count first takes effect. A rollover is a period wrap in period-wrap mode, or a carry out of bit 31 otherwise.
- R8: Writing control (address 0) with bit 11 set starts a capture. The snapshot takes the count value that is present in the cycle after the write. Control bit 11 reads 1 for the two cycles after the write, then reads 0.
- R9: A capture request made while control bit 11 reads 1 is ignored: the snapshot is not taken again.
- R10: A write to the time address (address 1) loads the count with the written value. This takes precedence over the step in that cycle. The trim sequence still advances when counting is enabled, and the snapshot is left unchanged.
- R11: The read map returns fixed values at each address:
  - Address 0 returns control: enable in bit 0, wrap-mode bits in [5:4], capture-busy in bit 11.
  - Address 1 returns the snapshot.
  - Address 2 returns the period.
  - Address 3 returns the correction register.
  - Address 4 returns the increment register, with its fields at [6:0] and [14:8].
  - Other addresses and bits return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data |
| wrap_pulse | output | 1 | One-cycle rollover pulse |

## Verification
Two collisions are provoked.

The first is a direct load landing in the same cycle as a substitute step. The correction interval is set to one so that every second enabled clock trims. Then two loads are written back to back, so one of them must fall on the trim cycle. Later snapshots then show whether the load won and whether the trim phase still advanced.

The second is a load written in the very cycle the capture is armed. The snapshot must then hold the pre-load count.

Both collisions are judged against a behavioural model that is compared with the read port and the wrap pulse on every clock.

// File: rtl/ntc_pkg.sv
package ntc_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_TIME   = 3'd1;
    localparam logic [ADDR_W-1:0] A_PERIOD = 3'd2;
    localparam logic [ADDR_W-1:0] A_CORR   = 3'd3;
    localparam logic [ADDR_W-1:0] A_INC    = 3'd4;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_WM_LO   = 4;
    localparam int CTRL_WM_HI   = 5;
    localparam int CTRL_CAP_BIT = 11;

    localparam int INC_SUB_LSB  = 8;

    typedef enum logic [1:0] {
        TRIM_OFF  = 2'd0,
        TRIM_WAIT = 2'd1,
        TRIM_FIRE = 2'd2
    } trim_state_t;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_HOLD  = 2'd2
    } cap_state_t;

endpackage

// File: rtl/ntc_regs.sv
module ntc_regs
    import ntc_pkg::*;
#(
    parameter int DW = 32,
    parameter int SW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic              cnt_en,
    output logic [1:0]        wm_bits,
    output logic [DW-1:0]     period,
    output logic [DW-1:0]     corr,
    output logic [SW-1:0]     step_norm,
    output logic [SW-1:0]     step_sub,
    output logic              ld,
    output logic [DW-1:0]     ld_val,
    output logic              corr_wr,
    output logic              cap_req
);

    logic wr_ctrl, wr_period, wr_inc;

    always_comb begin
        wr_ctrl   = wr_en && (wr_addr == A_CTRL);
        wr_period = wr_en && (wr_addr == A_PERIOD);
        wr_inc    = wr_en && (wr_addr == A_INC);
        corr_wr   = wr_en && (wr_addr == A_CORR);
        ld        = wr_en && (wr_addr == A_TIME);
        ld_val    = wr_data;
        cap_req   = wr_ctrl && wr_data[CTRL_CAP_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_en    <= 1'b0;
            wm_bits   <= 2'b00;
            period    <= '0;
            corr      <= '0;
            step_norm <= '0;
            step_sub  <= '0;
        end else begin
            if (wr_ctrl) begin
                cnt_en  <= wr_data[CTRL_RUN_BIT];
                wm_bits <= wr_data[CTRL_WM_HI:CTRL_WM_LO];
            end
            if (wr_period) begin
                period <= wr_data;
            end
            if (corr_wr) begin
                corr <= wr_data;
            end
            if (wr_inc) begin
                step_norm <= wr_data[SW-1:0];
                step_sub  <= wr_data[INC_SUB_LSB+SW-1:INC_SUB_LSB];
            end
        end
    end

endmodule

// File: rtl/ntc_trim.sv
module ntc_trim
    import ntc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          corr_wr,
    input  logic [DW-1:0] corr_wval,
    input  logic [DW-1:0] corr,
    output logic          use_sub
);

    trim_state_t   state_q, state_d;
    logic [DW-1:0] left_q, left_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        if (corr_wr) begin
            state_d = (corr_wval == '0) ? TRIM_OFF : TRIM_WAIT;
            left_d  = corr_wval;
        end else if (adv) begin
            unique case (state_q)
                TRIM_OFF: begin
                    state_d = TRIM_OFF;
                end
                TRIM_WAIT: begin
                    if (left_q <= DW'(1)) begin
                        state_d = TRIM_FIRE;
                        left_d  = '0;
                    end else begin
                        left_d  = left_q - DW'(1);
                    end
                end
                TRIM_FIRE: begin
                    state_d = (corr == '0) ? TRIM_OFF : TRIM_WAIT;
                    left_d  = corr;
                end
                default: begin
                    state_d = TRIM_OFF;
                    left_d  = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRIM_OFF;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    // outputs
    always_comb begin
        use_sub = adv && (state_q == TRIM_FIRE);
    end

    a_r5_no_trim_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (corr == '0) |-> !use_sub)
        else $error("a_r5_no_trim_when_zero");

    a_r4_single_substitute: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRIM_FIRE && adv) |=> (state_q != TRIM_FIRE))
        else $error("a_r4_single_substitute");

    a_r3_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !corr_wr) |=> $stable(state_q))
        else $error("a_r3_frozen_when_off");

endmodule

// File: rtl/ntc_capture.sv
module ntc_capture
    import ntc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_req,
    input  logic [DW-1:0] count,
    output logic [DW-1:0] snap,
    output logic          busy
);

    cap_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE:  state_d = cap_req ? CAP_ARMED : CAP_IDLE;
            CAP_ARMED: state_d = CAP_HOLD;
            CAP_HOLD:  state_d = CAP_IDLE;
            default:   state_d = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_IDLE;
            snap    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == CAP_ARMED) begin
                snap <= count;
            end
        end
    end

    always_comb begin
        busy = (state_q != CAP_IDLE);
    end

    a_r8_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_HOLD) |=> !busy)
        else $error("a_r8_busy_clears");

    a_r9_ignore_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cap_req && state_q != CAP_HOLD) |=> busy)
        else $error("a_r9_ignore_when_busy");

endmodule

// File: rtl/ntc_accum.sv
module ntc_accum #(
    parameter int DW = 32,
    parameter int SW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic          wrap_mode,
    input  logic [DW-1:0] period,
    input  logic [SW-1:0] step_norm,
    input  logic [SW-1:0] step_sub,
    input  logic          use_sub,
    input  logic          ld,
    input  logic [DW-1:0] ld_val,
    output logic [DW-1:0] count,
    output logic          wrap_pulse
);

    localparam int PAD = DW + 1 - SW;

    logic [SW-1:0] step;
    logic [DW:0]   sum;
    logic [DW:0]   less;
    logic          hit;
    logic [DW-1:0] count_d;
    logic          wrap_d;

    always_comb begin
        step = use_sub ? step_sub : step_norm;
        sum  = {1'b0, count} + {{PAD{1'b0}}, step};
        less = sum - {1'b0, period};
        hit  = wrap_mode ? (sum >= {1'b0, period}) : sum[DW];
        count_d = count;
        wrap_d  = 1'b0;
        if (ld) begin
            count_d = ld_val;
        end else if (cnt_en) begin
            wrap_d  = hit;
            count_d = (wrap_mode && hit) ? less[DW-1:0] : sum[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count      <= '0;
            wrap_pulse <= 1'b0;
        end else begin
            count      <= count_d;
            wrap_pulse <= wrap_d;
        end
    end

    a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !ld) |=> $stable(count))
        else $error("a_r3_hold_when_off");

    a_r7_pulse_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> $past(cnt_en && !ld))
        else $error("a_r7_pulse_needs_step");

    a_r6_stays_below_period: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_mode && cnt_en && !ld && count < period &&
         {{(DW-SW){1'b0}}, step} < period) |=> (count < $past(period)))
        else $error("a_r6_stays_below_period");

endmodule

// File: rtl/ns_time_counter.sv
module ns_time_counter
    import ntc_pkg::*;
#(
    parameter int DW = 32,
    parameter int SW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              wrap_pulse
);

    logic          cnt_en;
    logic [1:0]    wm_bits;
    logic          wrap_mode;
    logic [DW-1:0] period;
    logic [DW-1:0] corr;
    logic [SW-1:0] step_norm;
    logic [SW-1:0] step_sub;
    logic          ld;
    logic [DW-1:0] ld_val;
    logic          corr_wr;
    logic          cap_req;
    logic          use_sub;
    logic [DW-1:0] count;
    logic [DW-1:0] snap;
    logic          busy;

    ntc_regs #(.DW(DW), .SW(SW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cnt_en    (cnt_en),
        .wm_bits   (wm_bits),
        .period    (period),
        .corr      (corr),
        .step_norm (step_norm),
        .step_sub  (step_sub),
        .ld        (ld),
        .ld_val    (ld_val),
        .corr_wr   (corr_wr),
        .cap_req   (cap_req)
    );

    assign wrap_mode = &wm_bits;

    ntc_trim #(.DW(DW)) u_trim (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (cnt_en),
        .corr_wr   (corr_wr),
        .corr_wval (wr_data),
        .corr      (corr),
        .use_sub   (use_sub)
    );

    ntc_accum #(.DW(DW), .SW(SW)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .wrap_mode  (wrap_mode),
        .period     (period),
        .step_norm  (step_norm),
        .step_sub   (step_sub),
        .use_sub    (use_sub),
        .ld         (ld),
        .ld_val     (ld_val),
        .count      (count),
        .wrap_pulse (wrap_pulse)
    );

    ntc_capture #(.DW(DW)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_req (cap_req),
        .count   (count),
        .snap    (snap),
        .busy    (busy)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL: begin
                rd_data[CTRL_RUN_BIT]           = cnt_en;
                rd_data[CTRL_WM_HI:CTRL_WM_LO]  = wm_bits;
                rd_data[CTRL_CAP_BIT]           = busy;
            end
            A_TIME:   rd_data = snap;
            A_PERIOD: rd_data = period;
            A_CORR:   rd_data = corr;
            A_INC: begin
                rd_data[SW-1:0]                         = step_norm;
                rd_data[INC_SUB_LSB+SW-1:INC_SUB_LSB]   = step_sub;
            end
            default: rd_data = '0;
        endcase
    end

    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !cap_req) |=> (wrap_pulse == 1'b0))
        else $error("a_r10_load_wins");

endmodule

// File: tb/tb_ns_time_counter.sv
module tb_ns_time_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic [2:0]  rd_addr = 3'd0;
    logic [31:0] rd_data;
    logic        wrap_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ns_time_counter dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wrap_pulse(wrap_pulse)
    );

    // behavioural reference model
    logic [31:0] m_count = 0, m_snap = 0, m_period = 0, m_corr = 0, m_left = 0;
    logic [6:0]  m_n = 0, m_s = 0;
    logic        m_en = 0, m_wrap = 0;
    logic [1:0]  m_wm = 0;
    int          m_ts = 0, m_cap = 0;

    function automatic logic [31:0] m_read(input logic [2:0] a);
        logic [31:0] r;
        r = 0;
        case (a)
            3'd0: begin r[0] = m_en; r[5:4] = m_wm; r[11] = (m_cap != 0); end
            3'd1: r = m_snap;
            3'd2: r = m_period;
            3'd3: r = m_corr;
            3'd4: begin r[6:0] = m_n; r[14:8] = m_s; end
            default: r = 0;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        logic [32:0] sum;
        logic [31:0] nc, nl;
        logic [6:0]  st;
        logic        nw;
        int          nts, ncap;
        if (!rst_n) begin
            m_count = 0; m_snap = 0; m_period = 0; m_corr = 0; m_left = 0;
            m_n = 0; m_s = 0; m_en = 0; m_wrap = 0; m_wm = 0; m_ts = 0; m_cap = 0;
        end else begin
            st = (m_en && m_ts == 2) ? m_s : m_n;
            nc = m_count; nw = 0;
            if (wr_en && wr_addr == 3'd1) nc = wr_data;
            else if (m_en) begin
                sum = {1'b0, m_count} + {26'd0, st};
                if (m_wm == 2'b11) begin
                    if (sum >= {1'b0, m_period}) begin nc = 32'(sum - {1'b0, m_period}); nw = 1; end
                    else nc = sum[31:0];
                end else begin
                    nc = sum[31:0]; nw = sum[32];
                end
            end
            nts = m_ts; nl = m_left;
            if (wr_en && wr_addr == 3'd3) begin
                nts = (wr_data == 0) ? 0 : 1; nl = wr_data;
            end else if (m_en) begin
                if (m_ts == 1) begin
                    if (m_left <= 1) begin nts = 2; nl = 0; end else nl = m_left - 1;
                end else if (m_ts == 2) begin
                    nts = (m_corr == 0) ? 0 : 1; nl = m_corr;
                end
            end
            ncap = m_cap;
            if (m_cap == 0) begin
                if (wr_en && wr_addr == 3'd0 && wr_data[11]) ncap = 1;
            end else if (m_cap == 1) begin
                m_snap = m_count; ncap = 2;
            end else ncap = 0;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_en = wr_data[0]; m_wm = wr_data[5:4]; end
                    3'd2: m_period = wr_data;
                    3'd3: m_corr = wr_data;
                    3'd4: begin m_n = wr_data[6:0]; m_s = wr_data[14:8]; end
                    default: ;
                endcase
            end
            m_count = nc; m_wrap = nw; m_ts = nts; m_left = nl; m_cap = ncap;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compared on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R7 wrap_pulse", {31'd0, wrap_pulse}, {31'd0, m_wrap});
            check(rd_addr == 3'd1 ? "R8 snapshot read" : "R11 register read",
                  rd_data, m_read(rd_addr));
        end
    end

    logic [31:0] ctrl_sh = 0;

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic set_ctrl(input logic [31:0] d);
        ctrl_sh = d & 32'h31;
        wr(3'd0, ctrl_sh);
    endtask

    task automatic snap_check(input string tag);
        wr(3'd0, ctrl_sh | 32'h800);
        idle(2);
        rd_addr = 3'd1;
        @(negedge clk);
        check(tag, rd_data, m_snap);
        #0;
        @(posedge clk); #2;
    endtask

    logic [31:0] s1, s2;

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: all addresses read zero after reset
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            @(negedge clk);
            check("R1 reset read", rd_data, 32'd0);
            check("R1 reset wrap", {31'd0, wrap_pulse}, 32'd0);
            @(posedge clk); #2;
        end
        // R2: normal step
        wr(3'd4, 32'h0000_0908);
        set_ctrl(32'h1);
        idle(20);
        snap_check("R2 count by normal step");
        s1 = m_snap;
        check("R2 hand multiple of step", {29'd0, s1[2:0]}, 32'd0);
        // R3: hold while disabled
        set_ctrl(32'h0);
        snap_check("R3 hold first");
        s1 = rd_data;
        idle(10);
        snap_check("R3 hold second");
        check("R3 hold equal", rd_data, s1);
        // R5: corr zero, substitute never used
        wr(3'd1, 32'd0);
        wr(3'd4, 32'h0000_3203);
        set_ctrl(32'h1);
        idle(15);
        set_ctrl(32'h0);
        snap_check("R5 no substitute");
        check("R5 hand multiple of 3", rd_data % 3, 32'd0);
        // R4: trim every N+1
        wr(3'd1, 32'd0);
        wr(3'd4, 32'h0000_0905);
        wr(3'd3, 32'd3);
        set_ctrl(32'h1);
        idle(7);
        set_ctrl(32'h0);
        snap_check("R4 trimmed count");
        // 8 enabled clocks: steps 5,5,5,9,5,5,5,9
        check("R4 hand value", rd_data, 32'd48);
        set_ctrl(32'h1);
        idle(30);
        snap_check("R4 trimmed long run");
        // R10: load while counting; collision with substitute cycle
        wr(3'd3, 32'd1);
        idle(3);
        wr(3'd1, 32'd1000);
        wr(3'd1, 32'd2000);
        idle(5);
        snap_check("R10 load during trim");
        // R10: load in the armed cycle, snapshot keeps pre-load value
        wr(3'd0, ctrl_sh | 32'h800);
        wr(3'd1, 32'd777);
        idle(2);
        rd_addr = 3'd1;
        @(negedge clk);
        check("R10 snapshot unaffected by load", rd_data, m_snap);
        @(posedge clk); #2;
        // R9: capture requests back to back
        wr(3'd0, ctrl_sh | 32'h800);
        wr(3'd0, ctrl_sh | 32'h800);
        rd_addr = 3'd0;
        @(negedge clk);
        check("R9 busy bit", rd_data & 32'h800, 32'h800);
        @(posedge clk); #2;
        rd_addr = 3'd1;
        idle(3);
        snap_check("R9 busy request ignored");
        // R6: period wrap mode
        wr(3'd3, 32'd0);
        wr(3'd2, 32'd1000);
        wr(3'd4, 32'h0000_0008);
        wr(3'd1, 32'd950);
        set_ctrl(32'h31);
        idle(12);
        set_ctrl(32'h0);
        snap_check("R6 period wrap");
        check("R6 hand below period", {31'd0, rd_data < 32'd1000}, 32'd1);
        // R6: one wrap-mode bit only -> no period wrap
        wr(3'd1, 32'd990);
        set_ctrl(32'h11);
        idle(4);
        set_ctrl(32'h0);
        snap_check("R6 single bit no wrap");
        check("R6 hand above period", {31'd0, rd_data > 32'd1000}, 32'd1);
        // R7: natural carry rollover
        wr(3'd1, 32'hFFFF_FFF0);
        set_ctrl(32'h1);
        idle(5);
        set_ctrl(32'h0);
        snap_check("R7 carry rollover");
        // R11: register readbacks
        wr(3'd4, 32'hFFFF_FFFF);
        rd_addr = 3'd4;
        @(negedge clk);
        check("R11 inc fields", rd_data, 32'h0000_7F7F);
        @(posedge clk); #2;
        rd_addr = 3'd2;
        @(negedge clk);
        check("R11 period read", rd_data, 32'd1000);
        @(posedge clk); #2;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule